// File: doc/BRIEF.md
# Serial Audio Port Control and Status Register

This block is the control and status word of one direction (transmit or receive) of a serial audio port. Software uses it to enable interrupts, to enable the FIFO request towards a DMA engine, to start and stop the transmitter or receiver, to empty the FIFO, and to hold the serial logic in reset. The serial engine and the FIFO report events to it as single-cycle pulses or as live level signals. The block keeps these as flags and drives one interrupt line from the flags that are enabled.

The word has one bus port: a write strobe with a full data word, and a read word that always shows the current register image. Three of the flags are sticky and are cleared by writing one to them. The FIFO warning and FIFO request flags follow the FIFO level and cannot be cleared by a write. The FIFO-reset command is a one-shot. Stopping the transfer only takes effect at the next frame boundary.

Top module: `audio_port_csr`

## Requirements
- R1: After reset, rd_data is zero and irq, dma_req, fifo_clr, serial_rst and xfer_en are all low.
- R2: Interrupt enables are read/write bits 4..0, in the order word start (0), sync error (1), FIFO error (2), FIFO warning (3), FIFO request (4). The matching flags sit at the same order shifted up by FLAG_SHIFT (default 8, giving bits 12..8).
- R3: The word start, sync error and FIFO error flags are set one cycle after their event pulse and stay set. Writing one to a flag bit clears it. Writing zero to it leaves it unchanged.
- R4: An event pulse in the same cycle as a write that clears its flag wins: the flag stays set.
- R5: The FIFO warning and FIFO request flags show the value of fifo_warn_lvl and fifo_req_lvl sampled at the previous clock edge. Writes do not change them.
- R6: irq is high exactly when some flag and its matching enable are both set.
- R7: Bit 16 enables the FIFO request towards the DMA engine. dma_req is high when that bit and the FIFO request flag are both set, independently of the interrupt enables.
- R8: Writing one to bit 24 drives fifo_clr high for exactly the one cycle after the write. Bit 24 always reads zero.
- R9: Bit 25 is a soft reset. While it is one, serial_rst is high, the three sticky flags and the transfer enable read zero, and event pulses are ignored. Writing zero releases the soft reset.
- R10: Bit 31 is the transfer enable. Writing one sets it in the next cycle. Writing zero while it is set keeps it reading one until a frame_end pulse that arrives after the write; it clears in the cycle after that pulse. Writing one before that pulse cancels the pending stop.
- R11: xfer_en always equals rd_data bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the register |
| wr_data | input | DATA_W | Write data word |
| rd_data | output | DATA_W | Current register image |
| ev_word_start | input | 1 | Pulse: a word has started |
| ev_sync_err | input | 1 | Pulse: frame sync error |
| ev_fifo_err | input | 1 | Pulse: FIFO underrun or overflow |
| fifo_warn_lvl | input | 1 | Level: FIFO empty (transmit) or full (receive) |
| fifo_req_lvl | input | 1 | Level: FIFO watermark reached |
| frame_end | input | 1 | Pulse: the current frame has ended |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | FIFO request to the DMA engine |
| fifo_clr | output | 1 | One-cycle command to empty the FIFO |
| serial_rst | output | 1 | Held reset to the serial logic |
| xfer_en | output | 1 | Transmitter or receiver enable |

## Verification
The bench builds the block with its default parameters: a 32-bit word, flags shifted by 8, and the control bits at 16, 24, 25 and 31. With these values one table of writes and event pulses can reach every bit position. The table covers clears colliding with events, writes to the level flags, masked and unmasked interrupts, and a stop write that lands on a frame boundary or is cancelled before one. It also covers the one-shot FIFO reset and a soft reset written together with the transfer enable.

// File: rtl/audio_port_csr.sv
module audio_port_csr #(
  parameter int DATA_W       = 32,
  parameter int FLAG_SHIFT   = 8,
  parameter int DMA_EN_BIT   = 16,
  parameter int FIFO_RST_BIT = 24,
  parameter int SOFT_RST_BIT = 25,
  parameter int XFER_EN_BIT  = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ev_word_start,
  input  logic              ev_sync_err,
  input  logic              ev_fifo_err,
  input  logic              fifo_warn_lvl,
  input  logic              fifo_req_lvl,
  input  logic              frame_end,
  output logic              irq,
  output logic              dma_req,
  output logic              fifo_clr,
  output logic              serial_rst,
  output logic              xfer_en
);

  localparam int NUM_EV   = 5;
  localparam int NUM_STKY = 3;
  localparam int REQ_IDX  = 4;

  logic [NUM_EV-1:0]   ie_q, flag_q, ev_in;
  logic [NUM_STKY-1:0] clr_w, sticky_nxt;
  logic dma_en_q, fr_q, sr_q, en_q, stop_pend_q, sr_nxt;
  logic unused_bits;

  assign ev_in  = {fifo_req_lvl, fifo_warn_lvl, ev_fifo_err, ev_sync_err, ev_word_start};
  assign clr_w  = wr_en ? wr_data[FLAG_SHIFT +: NUM_STKY] : '0;
  assign sr_nxt = wr_en ? wr_data[SOFT_RST_BIT] : sr_q;
  assign sticky_nxt = sr_nxt ? '0 : ((flag_q[NUM_STKY-1:0] & ~clr_w) | ev_in[NUM_STKY-1:0]);
  assign unused_bits = ^wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q     <= '0;
      flag_q   <= '0;
      dma_en_q <= 1'b0;
      fr_q     <= 1'b0;
      sr_q     <= 1'b0;
    end else begin
      flag_q <= {ev_in[NUM_EV-1:NUM_STKY], sticky_nxt};
      sr_q   <= sr_nxt;
      fr_q   <= wr_en & wr_data[FIFO_RST_BIT];
      if (wr_en) begin
        ie_q     <= wr_data[NUM_EV-1:0];
        dma_en_q <= wr_data[DMA_EN_BIT];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q        <= 1'b0;
      stop_pend_q <= 1'b0;
    end else if (sr_nxt) begin
      en_q        <= 1'b0;
      stop_pend_q <= 1'b0;
    end else if (wr_en && wr_data[XFER_EN_BIT]) begin
      en_q        <= 1'b1;
      stop_pend_q <= 1'b0;
    end else if (wr_en && en_q) begin
      stop_pend_q <= 1'b1;
    end else if (stop_pend_q && frame_end) begin
      en_q        <= 1'b0;
      stop_pend_q <= 1'b0;
    end
  end

  always_comb begin
    rd_data = '0;
    rd_data[NUM_EV-1:0]         = ie_q;
    rd_data[FLAG_SHIFT +: NUM_EV] = flag_q;
    rd_data[DMA_EN_BIT]         = dma_en_q;
    rd_data[SOFT_RST_BIT]       = sr_q;
    rd_data[XFER_EN_BIT]        = en_q;
  end

  assign irq        = |(flag_q & ie_q);
  assign dma_req    = dma_en_q & flag_q[REQ_IDX];
  assign fifo_clr   = fr_q;
  assign serial_rst = sr_q;
  assign xfer_en    = en_q;

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[FLAG_SHIFT] && !ev_word_start) |=> !rd_data[FLAG_SHIFT]); // R3
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fifo_err && wr_en && wr_data[FLAG_SHIFT+2] && !wr_data[SOFT_RST_BIT]) |=> rd_data[FLAG_SHIFT+2]); // R4
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[NUM_EV-1:0] == '0) |-> !irq); // R6
  AST_FIFO_CLR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[FIFO_RST_BIT]) |=> fifo_clr); // R8
  AST_FIFO_CLR_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_clr && !wr_en) |=> !fifo_clr); // R8
  AST_SRST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    serial_rst |-> (!xfer_en && rd_data[FLAG_SHIFT +: NUM_STKY] == '0)); // R9
  AST_STOP_DEFERRED: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_en && wr_en && !wr_data[XFER_EN_BIT] && !wr_data[SOFT_RST_BIT]) |=> xfer_en); // R10

endmodule

// File: tb/audio_port_csr_bench.sv
module audio_port_csr_bench;

  typedef struct packed {
    logic        wr;
    logic [31:0] wdata;
    logic [4:0]  ev;     // {word_start, sync_err, fifo_err, warn_lvl, req_lvl}
    logic        fend;
    logic [31:0] exp_rd;
    logic [4:0]  exp_out; // {irq, dma_req, fifo_clr, xfer_en, serial_rst}
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 32'h0000_001F, 5'b00000, 1'b0, 32'h0000_001F, 5'b00000}, // R2 enables
    '{1'b0, 32'h0,         5'b10000, 1'b0, 32'h0000_011F, 5'b10000}, // R3 set
    '{1'b0, 32'h0,         5'b00000, 1'b0, 32'h0000_011F, 5'b10000}, // R3 sticky
    '{1'b1, 32'h0000_001F, 5'b00000, 1'b0, 32'h0000_011F, 5'b10000}, // R3 write zero
    '{1'b1, 32'h0000_011F, 5'b00000, 1'b0, 32'h0000_001F, 5'b00000}, // R3 clear
    '{1'b0, 32'h0,         5'b01100, 1'b0, 32'h0000_061F, 5'b10000}, // R3
    '{1'b1, 32'h0000_061F, 5'b00100, 1'b0, 32'h0000_041F, 5'b10000}, // R4
    '{1'b1, 32'h0000_041F, 5'b00000, 1'b0, 32'h0000_001F, 5'b00000}, // R3
    '{1'b0, 32'h0,         5'b00011, 1'b0, 32'h0000_181F, 5'b10000}, // R5
    '{1'b1, 32'h0000_181F, 5'b00011, 1'b0, 32'h0000_181F, 5'b10000}, // R5 no clear
    '{1'b0, 32'h0,         5'b00000, 1'b0, 32'h0000_001F, 5'b00000}, // R5 follow
    '{1'b1, 32'h0000_0000, 5'b10000, 1'b0, 32'h0000_0100, 5'b00000}, // R6 masked
    '{1'b1, 32'h0000_0001, 5'b00000, 1'b0, 32'h0000_0101, 5'b10000}, // R6 unmasked
    '{1'b1, 32'h0000_0100, 5'b00000, 1'b0, 32'h0000_0000, 5'b00000}, // R3
    '{1'b1, 32'h0001_0000, 5'b00001, 1'b0, 32'h0001_1000, 5'b01000}, // R7
    '{1'b0, 32'h0,         5'b00000, 1'b0, 32'h0001_0000, 5'b00000}, // R7
    '{1'b1, 32'h8000_0000, 5'b00000, 1'b0, 32'h8000_0000, 5'b00010}, // R10 start
    '{1'b1, 32'h0000_0000, 5'b00000, 1'b0, 32'h8000_0000, 5'b00010}, // R10 stop deferred
    '{1'b0, 32'h0,         5'b00000, 1'b0, 32'h8000_0000, 5'b00010}, // R10
    '{1'b0, 32'h0,         5'b00000, 1'b1, 32'h0000_0000, 5'b00000}, // R10 frame end
    '{1'b1, 32'h8000_0000, 5'b00000, 1'b0, 32'h8000_0000, 5'b00010}, // R11
    '{1'b1, 32'h0000_0000, 5'b00000, 1'b1, 32'h8000_0000, 5'b00010}, // R10 same-cycle end
    '{1'b1, 32'h8000_0000, 5'b00000, 1'b0, 32'h8000_0000, 5'b00010}, // R10 cancel
    '{1'b0, 32'h0,         5'b00000, 1'b1, 32'h8000_0000, 5'b00010}, // R10 no pending
    '{1'b1, 32'h0000_0000, 5'b00000, 1'b0, 32'h8000_0000, 5'b00010}, // R10
    '{1'b0, 32'h0,         5'b00000, 1'b1, 32'h0000_0000, 5'b00000}, // R10
    '{1'b1, 32'h0100_0000, 5'b00000, 1'b0, 32'h0000_0000, 5'b00100}, // R8
    '{1'b0, 32'h0,         5'b10000, 1'b0, 32'h0000_0100, 5'b00000}, // R8 one shot
    '{1'b1, 32'h8200_0000, 5'b00000, 1'b0, 32'h0200_0000, 5'b00001}, // R9 hold
    '{1'b0, 32'h0,         5'b10100, 1'b0, 32'h0200_0000, 5'b00001}, // R9 ignore
    '{1'b1, 32'h0000_0000, 5'b00000, 1'b0, 32'h0000_0000, 5'b00000}  // R9 release
  };

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, frame_end = 1'b0;
  logic [31:0] wr_data = '0, rd_data;
  logic ev_ws = 1'b0, ev_se = 1'b0, ev_fe = 1'b0, warn = 1'b0, req = 1'b0;
  logic irq, dma_req, fifo_clr, serial_rst, xfer_en;
  int checks = 0, fails = 0, cycles = 0;

  always #10 clk = ~clk;

  audio_port_csr u_audio_port_csr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .ev_word_start(ev_ws), .ev_sync_err(ev_se), .ev_fifo_err(ev_fe),
    .fifo_warn_lvl(warn), .fifo_req_lvl(req), .frame_end(frame_end),
    .irq(irq), .dma_req(dma_req), .fifo_clr(fifo_clr), .serial_rst(serial_rst),
    .xfer_en(xfer_en)
  );

  task automatic drive(input vec_t v);
    wr_en = v.wr; wr_data = v.wdata; frame_end = v.fend;
    {ev_ws, ev_se, ev_fe, warn, req} = v.ev;
  endtask

  task automatic check(input string tag, input logic [31:0] exp_rd, input logic [4:0] exp_out);
    logic [4:0] got;
    got = {irq, dma_req, fifo_clr, xfer_en, serial_rst};
    checks++;
    if (rd_data !== exp_rd || got !== exp_out) begin
      fails++;
      $display("FAIL %s rd=%h out=%b expected rd=%h out=%b", tag, rd_data, got, exp_rd, exp_out);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", 32'h0, 5'b00000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", 32'h0, 5'b00000);
    drive(VEC[0]);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      check($sformatf("row %0d (see table tag)", i), VEC[i].exp_rd, VEC[i].exp_out);
      if (i + 1 < NV) drive(VEC[i + 1]);
      else drive('0);
    end
    // R10 enable works again after soft reset release; R11 xfer_en tracks bit 31
    wr_en = 1'b1; wr_data = 32'h8000_0004;
    @(negedge clk);
    wr_en = 1'b0;
    check("R10 R11 enable after release", 32'h8000_0004, 5'b00010);
    // R1 asynchronous reset clears flags and enable mid-operation
    ev_fe = 1'b1;
    @(negedge clk);
    ev_fe = 1'b0;
    check("R3 fifo err flag", 32'h8000_0404, 5'b10010);
    rst_n = 1'b0;
    #3;
    check("R1 async reset", 32'h0, 5'b00000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", 32'h0, 5'b00000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule